// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into a framed asynchronous bit stream on a single output line. A small set of mode inputs chooses the framing. The rate code sets how many clock periods make up one bit time. Parity can be switched on, and its sense chosen as even or odd. The stop code sets one, one and a half or two stop bits. A fourth stop code parks the block in an idle synchronous-mode state in which it sends nothing.

Characters enter through a valid/ready handshake. While a character is being shifted out, `busy` is high and `in_ready` is low. The mode inputs are captured at the moment a character is accepted, so software may reprogram them during a frame without corrupting it. The line idles high.

Top module: `serial_char_tx`

## Requirements
- R1: After reset the line is high, `busy` is low, and `in_ready` is high whenever the stop code is not 00.
- R2: A frame is a low start bit, then the data bits least significant bit first, then high stop bits. After the stop bits the line is high.
- R3: Rate code 00 gives 1 clock per bit, 01 gives 16 (`MUL_LO`), 10 gives 32 (`MUL_MID`) and 11 gives 64 (`MUL_HI`) clocks per bit.
- R4: When the parity-enable input is 1, one parity bit follows the data. With the parity-sense input at 0, the ones in data plus parity add up to an even count. With it at 1, they add up to an odd count.
- R5: Stop code 01 holds the line high for one bit time and code 11 for two bit times. Code 10 holds it for one and a half bit times, except at rate code 00, where it holds it for 2 clocks.
- R6: With stop code 00 and no frame in progress, `in_ready` is low, the line stays high, `busy` stays low, and `in_valid` starts nothing.
- R7: The mode inputs are sampled on the accepting clock edge. Changes during a frame take effect only for the next character.
- R8: `busy` is high from the cycle after acceptance through the last clock of the stop period. `in_ready` is never high while `busy` is high, and it returns high on the first cycle after the stop period.
- R9: A character is taken only on a clock edge where `in_valid` and `in_ready` are both high. With `in_valid` low, no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bit timing counts its periods |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 2 | Clocks-per-bit code (00:1, 01:16, 10:32, 11:64) |
| cfg_par_en | input | 1 | 1 inserts a parity bit after the data |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_stop | input | 2 | 00 synchronous idle, 01 one stop bit, 10 one and a half, 11 two |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character to send, LSB first |
| in_ready | output | 1 | Block can take a character |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its defaults: 8 data bits and multipliers of 16, 32 and 64. These are the only values at which the rate codes match their nominal bit times. At these values every rate code, including the unit rate with its rounded one-and-a-half stop period, fits a frame in under a thousand cycles. Random frames can therefore cover every combination of rate, parity and stop code, alongside directed checks of the synchronous idle state and of mode changes made mid-frame.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] rate;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop;
   } tx_mode_t;

   localparam logic [1:0] STOP_SYNC = 2'b00;
   localparam logic [1:0] STOP_ONE  = 2'b01;
   localparam logic [1:0] STOP_HALF = 2'b10;
   localparam logic [1:0] STOP_TWO  = 2'b11;

endpackage

// File: rtl/tx_len_table.sv
module tx_len_table #(
   parameter int MUL_LO  = 16,
   parameter int MUL_MID = 32,
   parameter int MUL_HI  = 64,
   parameter int CNT_W   = 8
) (
   input  logic [1:0]       rate,
   input  logic [1:0]       stop,
   output logic [CNT_W-1:0] bit_len,
   output logic [CNT_W-1:0] stop_len
);
   import serial_tx_pkg::*;

   logic [CNT_W-1:0] mul_tab [4];

   for (genvar i = 0; i < 4; i++) begin : g_tab
      localparam int MULV = (i == 0) ? 1 : (i == 1) ? MUL_LO : (i == 2) ? MUL_MID : MUL_HI;
      assign mul_tab[i] = CNT_W'(MULV);
   end

   assign bit_len = mul_tab[rate];

   always_comb begin
      unique case (stop)
         STOP_HALF: stop_len = (bit_len == CNT_W'(1)) ? CNT_W'(2)
                                                      : bit_len + (bit_len >> 1);
         STOP_TWO:  stop_len = bit_len << 1;
         default:   stop_len = bit_len;
      endcase
   end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= len - CNT_W'(1);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
   end

   assign last = (cnt == '0);

   // R3: a loaded period counts down from its length
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(len) - CNT_W'(1)));

   // R3: no load means the count only moves down
   p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
   parameter int DATA_W  = 8,
   parameter int MUL_LO  = 16,
   parameter int MUL_MID = 32,
   parameter int MUL_HI  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_rate,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic [1:0]        cfg_stop,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              tx_line,
   output logic              busy
);
   import serial_tx_pkg::*;

   localparam int MAX_MUL  = (MUL_HI > MUL_MID) ? ((MUL_HI > MUL_LO) ? MUL_HI : MUL_LO)
                                                : ((MUL_MID > MUL_LO) ? MUL_MID : MUL_LO);
   localparam int CNT_W    = $clog2(2 * MAX_MUL + 1);
   localparam int IDX_W    = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("serial_char_tx: DATA_W must be at least 2");
   end
   if (MUL_LO < 2 || MUL_MID < 2 || MUL_HI < 2) begin : g_bad_mul
      $error("serial_char_tx: multipliers must be at least 2");
   end
   if ((MUL_LO % 2) != 0 || (MUL_MID % 2) != 0 || (MUL_HI % 2) != 0) begin : g_odd_mul
      $error("serial_char_tx: multipliers must be even for half stop bits");
   end

   tx_state_e         state, state_d;
   tx_mode_t          mode_q, mode_in, mode_sel;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  bit_idx;
   logic              par_q;
   logic              accept, t_load, t_last;
   logic [CNT_W-1:0]  t_len, bit_len, stop_len;

   assign mode_in  = '{rate: cfg_rate, par_en: cfg_par_en, par_odd: cfg_par_odd, stop: cfg_stop};
   assign in_ready = (state == ST_IDLE) && (cfg_stop != STOP_SYNC);
   assign busy     = (state != ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign mode_sel = accept ? mode_in : mode_q;

   tx_len_table #(
      .MUL_LO (MUL_LO),
      .MUL_MID(MUL_MID),
      .MUL_HI (MUL_HI),
      .CNT_W  (CNT_W)
   ) u_len (
      .rate    (mode_sel.rate),
      .stop    (mode_sel.stop),
      .bit_len (bit_len),
      .stop_len(stop_len)
   );

   tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (t_load),
      .len  (t_len),
      .last (t_last)
   );

   always_comb begin
      state_d = state;
      t_load  = 1'b0;
      t_len   = bit_len;
      unique case (state)
         ST_IDLE: if (accept) begin
            state_d = ST_START;
            t_load  = 1'b1;
         end
         ST_START: if (t_last) begin
            state_d = ST_DATA;
            t_load  = 1'b1;
         end
         ST_DATA: if (t_last) begin
            t_load = 1'b1;
            if (bit_idx == LAST_IDX) begin
               if (mode_q.par_en) begin
                  state_d = ST_PAR;
               end else begin
                  state_d = ST_STOP;
                  t_len   = stop_len;
               end
            end
         end
         ST_PAR: if (t_last) begin
            state_d = ST_STOP;
            t_load  = 1'b1;
            t_len   = stop_len;
         end
         ST_STOP: if (t_last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= '0;
         shreg   <= '0;
         bit_idx <= '0;
         par_q   <= 1'b0;
      end else begin
         state <= state_d;
         if (accept) begin
            mode_q  <= mode_in;
            shreg   <= in_data;
            bit_idx <= '0;
            par_q   <= (^in_data) ^ cfg_par_odd;
         end else if (state == ST_DATA && t_last && bit_idx != LAST_IDX) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + IDX_W'(1);
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_START: tx_line = 1'b0;
         ST_DATA:  tx_line = shreg[0];
         ST_PAR:   tx_line = par_q;
         default:  tx_line = 1'b1;
      endcase
   end

   // R8: ready and busy never overlap
   p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !busy);

   // R6: synchronous idle keeps the line high and refuses characters
   p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stop == STOP_SYNC && !busy) |-> (tx_line && !in_ready));

   // R2: an accepted character opens with a low start bit
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!tx_line && busy));

   // R1: with no frame in progress the line is high
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_line);

   // R9: without a valid, an idle block stays idle
   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !in_valid) |=> !busy);

endmodule

// File: tb/serial_char_tx_tb.sv
module serial_char_tx_tb;

   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cfg_rate = 2'b00;
   logic              cfg_par_en = 1'b0;
   logic              cfg_par_odd = 1'b0;
   logic [1:0]        cfg_stop = 2'b01;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_ready, tx_line, busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   serial_char_tx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_rate   (cfg_rate),
      .cfg_par_en (cfg_par_en),
      .cfg_par_odd(cfg_par_odd),
      .cfg_stop   (cfg_stop),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .tx_line    (tx_line),
      .busy       (busy)
   );

   function automatic int mul_of(input logic [1:0] r);
      case (r)
         2'b00:   return 1;
         2'b01:   return 16;
         2'b10:   return 32;
         default: return 64;
      endcase
   endfunction

   function automatic int stop_clks(input logic [1:0] r, input logic [1:0] s);
      int m = mul_of(r);
      case (s)
         2'b10:   return (m == 1) ? 2 : m + m / 2;
         2'b11:   return 2 * m;
         default: return m;
      endcase
   endfunction

   function automatic int frame_clks(input logic [1:0] r, input logic pe, input logic [1:0] s);
      return mul_of(r) * (1 + DATA_W + (pe ? 1 : 0)) + stop_clks(r, s);
   endfunction

   function automatic logic exp_line(input int k, input logic [DATA_W-1:0] d,
                                     input logic [1:0] r, input logic pe, input logic po);
      int m = mul_of(r);
      int b = k / m;
      if (b == 0) return 1'b0;
      if (b <= DATA_W) return d[b-1];
      if (pe && b == DATA_W + 1) return (^d) ^ po;
      return 1'b1;
   endfunction

   task automatic check(input bit ok, input string req, input int got, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0d expected=%0d", req, got, expv);
      end
   endtask

   // Sends one frame and compares every cycle; optionally scrambles the mode mid-frame (R7)
   task automatic send_frame(input logic [DATA_W-1:0] d, input logic [1:0] r,
                             input logic pe, input logic po, input logic [1:0] s,
                             input bit scramble);
      int t = frame_clks(r, pe, s);
      int bad_k = -1;
      logic bad_got = 1'b0;
      bit flag_bad = 1'b0;
      @(negedge clk);
      cfg_rate = r; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = s;
      in_data = d; in_valid = 1'b1;
      check(in_ready === 1'b1, "R9 ready before accept", int'(in_ready), 1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_data = $urandom();
      if (scramble) begin
         cfg_rate = $urandom(); cfg_par_en = $urandom(); cfg_par_odd = $urandom();
         cfg_stop = 2'($urandom_range(1, 3));
      end
      for (int k = 0; k < t; k++) begin
         if (k > 0) @(negedge clk);
         if (tx_line !== exp_line(k, d, r, pe, po) && bad_k < 0) begin
            bad_k = k; bad_got = tx_line;
         end
         if (busy !== 1'b1 || in_ready !== 1'b0) flag_bad = 1'b1;
      end
      check(bad_k < 0, scramble ? "R7 frame under mid-frame mode change"
                                : "R2/R3/R4/R5 frame waveform",
            int'(bad_got), (bad_k < 0) ? 0 : int'(exp_line(bad_k, d, r, pe, po)));
      check(!flag_bad, "R8 busy high and ready low during frame", int'(flag_bad), 0);
      @(negedge clk);
      check(busy === 1'b0 && tx_line === 1'b1, "R8 idle right after stop period",
            int'({busy, tx_line}), 1);
      if (cfg_stop != 2'b00)
         check(in_ready === 1'b1, "R8 ready back after stop period", int'(in_ready), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog got=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int seed_v;
      seed_v = $urandom(20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1,
            "R1 reset state", int'({tx_line, busy, in_ready}), 5);

      // R9: no valid, nothing starts
      repeat (10) begin
         @(negedge clk);
         if (busy !== 1'b0 || tx_line !== 1'b1) break;
      end
      check(busy === 1'b0 && tx_line === 1'b1, "R9 idle without valid", int'(busy), 0);

      // Directed corners: x1 with 1.5 stop (R5), each rate, parity senses (R4)
      send_frame(8'hA5, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0);
      send_frame(8'h01, 2'b00, 1'b1, 1'b0, 2'b01, 1'b0);
      send_frame(8'h01, 2'b00, 1'b1, 1'b1, 2'b11, 1'b0);
      send_frame(8'hFF, 2'b01, 1'b1, 1'b1, 2'b10, 1'b0);
      send_frame(8'h3C, 2'b10, 1'b0, 1'b0, 2'b11, 1'b0);
      send_frame(8'h80, 2'b11, 1'b1, 1'b0, 2'b10, 1'b0);

      // R6: synchronous idle state refuses characters
      @(negedge clk);
      cfg_stop = 2'b00; in_valid = 1'b1; in_data = 8'h00;
      begin
         bit sync_bad = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (in_ready !== 1'b0 || tx_line !== 1'b1 || busy !== 1'b0) sync_bad = 1'b1;
         end
         check(!sync_bad, "R6 sync idle holds line high, ready low", int'(sync_bad), 0);
      end
      in_valid = 1'b0; cfg_stop = 2'b01;
      @(negedge clk);
      check(in_ready === 1'b1 && busy === 1'b0 && tx_line === 1'b1,
            "R6 no frame started by valid in sync idle", int'({in_ready, busy, tx_line}), 5);

      // R7: mode scrambled during frames
      send_frame(8'h5A, 2'b01, 1'b1, 1'b0, 2'b11, 1'b1);
      send_frame(8'hC3, 2'b00, 1'b0, 1'b1, 2'b10, 1'b1);

      // Random frames
      for (int n = 0; n < 40; n++) begin
         logic [1:0] r = 2'($urandom());
         if ($urandom_range(0, 3) != 0) r = 2'($urandom_range(0, 1));
         send_frame(8'($urandom()), r, 1'($urandom()), 1'($urandom()),
                    2'($urandom_range(1, 3)), 1'($urandom_range(0, 3) == 0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule